// File: doc/BRIEF.md
# Grouped Pad Event and Wake Collector

This block gathers per-pad event flags from a configurable number of pads and presents them to a host as banks of 32-bit group words, 24 pads to a group. For each group there is a sticky interrupt-status word, an interrupt-enable word, a sticky wake-status word and a wake-enable word. Status bits latch one-cycle event pulses from external detectors and are cleared by writing ones. A single level-sensitive interrupt line rises when any pad has both its status and enable bit set; a separate wake line rises when a pad has wake status and wake enable set and is not steered to the system-control path.

Per-pad host ownership, the steering bits and the event pulses all arrive as inputs from pad configuration logic outside this block. A pad the host does not own never gets its interrupt-status bit set. The last group may be partly populated; its unused bits stay zero. A read-only word gives the base offset of the per-pad configuration area, and a read-only ownership bank mirrors the ownership inputs.

Top module: `gpi_event_collector`

## Requirements
- R1: Pad p maps to group word p/24, bit p%24, in every bank; the group word of a bank lives at the bank base plus 4 times the group number.
- R2: An interrupt event pulse on an owned pad sets its status bit at offset 0x100 bank on the next clock edge, and the bit stays set with no further events.
- R3: Writing a word to a status bank clears exactly the bits written as 1; bits written as 0 keep their value.
- R4: When an event and a clearing write hit the same status bit in the same cycle, the bit ends set.
- R5: An interrupt event on a pad whose ownership input is 0 leaves its status bit unchanged.
- R6: `irq_out` equals, one cycle later, the OR over all pads of interrupt status AND interrupt enable (enable bank at 0x120).
- R7: Bits for pad indices at or above the pad count, and whole group words beyond the group count, read 0 and ignore writes in every bank.
- R8: A wake event pulse sets the pad's wake-status bit (bank at 0x140), which is sticky and cleared by writing 1.
- R9: `wake_out` equals, one cycle later, the OR over pads of wake status AND wake enable (bank at 0x160) AND NOT the pad's steering input.
- R10: Offset 0x00C reads the configuration-area base parameter; the ownership bank at 0x0A0 reads back the ownership inputs.
- R11: After reset every status and enable word reads 0 and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register word |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| int_evt | input | NUM_PADS | One-cycle interrupt event pulses per pad |
| wake_evt | input | NUM_PADS | One-cycle wake event pulses per pad |
| host_own | input | NUM_PADS | 1 when the host owns the pad |
| route_sci | input | NUM_PADS | 1 when the pad is steered to the system-control path |
| irq_out | output | 1 | Registered level interrupt |
| wake_out | output | 1 | Registered wake request |

## Verification
The checks assume event pulses arrive only on the declared pad inputs and that the bus issues at most one write per cycle to a word-aligned address. The stickiness property only reasons about cycles with no bus write, so the stimulus changes status words solely through event pulses and explicit clearing writes, driven half a cycle away from the sampling edge. Ownership and steering inputs are changed only between scenarios or a full cycle before the effect is sampled.

// File: rtl/gpi_pkg.sv
// Shared constants and the bank selector type for the pad event collector.
// Assumes every bank occupies an aligned 32-byte window (at most 8 groups).
package gpi_pkg;
    localparam int GROUP_PADS = 24;
    localparam int WORD_W     = 32;
    localparam int MAX_GROUPS = 8;
    localparam int GIDX_W     = 3;

    // Bank window bases (bits above the 32-byte window)
    localparam logic [11:0] OWN_BASE  = 12'h0A0;
    localparam logic [11:0] ISTS_BASE = 12'h100;
    localparam logic [11:0] IEN_BASE  = 12'h120;
    localparam logic [11:0] WSTS_BASE = 12'h140;
    localparam logic [11:0] WEN_BASE  = 12'h160;
    localparam logic [11:0] CFG_ADDR  = 12'h00C;

    typedef enum logic [2:0] {
        BK_NONE,
        BK_CFG,
        BK_OWN,
        BK_ISTS,
        BK_IEN,
        BK_WSTS,
        BK_WEN
    } bank_e;
endpackage

// File: rtl/gpi_addr_decode.sv
// Address decoder: splits a byte address into a bank selector and a group index.
// Assumes ADDR_W >= 12 and word-aligned accesses; unaligned addresses select nothing.
module gpi_addr_decode
    import gpi_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output bank_e             bank,
    output logic [GIDX_W-1:0] gidx
);
    logic [ADDR_W-6:0] win;

    assign win  = addr[ADDR_W-1:5];
    assign gidx = addr[4:2];

    // Match the 32-byte window against each bank base
    always_comb begin
        bank = BK_NONE;
        if (addr[1:0] == 2'b00) begin
            if (addr == ADDR_W'(CFG_ADDR))                  bank = BK_CFG;
            else if (win == (ADDR_W-5)'(OWN_BASE  >> 5))    bank = BK_OWN;
            else if (win == (ADDR_W-5)'(ISTS_BASE >> 5))    bank = BK_ISTS;
            else if (win == (ADDR_W-5)'(IEN_BASE  >> 5))    bank = BK_IEN;
            else if (win == (ADDR_W-5)'(WSTS_BASE >> 5))    bank = BK_WSTS;
            else if (win == (ADDR_W-5)'(WEN_BASE  >> 5))    bank = BK_WEN;
        end
    end
endmodule

// File: rtl/gpi_group.sv
// One 24-pad group: holds the four bank words for its pads and reports
// whether any pad has a pending enabled interrupt or wake.
// Assumes event inputs are single-cycle pulses; unpopulated bits are masked.
module gpi_group
    import gpi_pkg::*;
#(
    parameter int GROUP_IDX = 0,
    parameter int NUM_PADS  = 40
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [GROUP_PADS-1:0] int_evt,
    input  logic [GROUP_PADS-1:0] wake_evt,
    input  logic [GROUP_PADS-1:0] own,
    input  logic [GROUP_PADS-1:0] sci,
    input  logic                  wr_ists,
    input  logic                  wr_ien,
    input  logic                  wr_wsts,
    input  logic                  wr_wen,
    input  logic [GROUP_PADS-1:0] wdata,
    output logic [GROUP_PADS-1:0] ists,
    output logic [GROUP_PADS-1:0] ien,
    output logic [GROUP_PADS-1:0] wsts,
    output logic [GROUP_PADS-1:0] wen,
    output logic                  irq_hit,
    output logic                  wake_hit
);
    localparam int REMAIN = NUM_PADS - GROUP_IDX * GROUP_PADS;
    localparam int VALID  = (REMAIN >= GROUP_PADS) ? GROUP_PADS : REMAIN;
    localparam logic [GROUP_PADS-1:0] MASK =
        (VALID >= GROUP_PADS) ? {GROUP_PADS{1'b1}}
                              : ((GROUP_PADS'(1) << VALID) - GROUP_PADS'(1));

    logic [GROUP_PADS-1:0] ists_clr, wsts_clr;

    assign ists_clr = wr_ists ? wdata : '0;
    assign wsts_clr = wr_wsts ? wdata : '0;

    // Interrupt status: clear by write-1, owned events set and win over clears
    always_ff @(posedge clk) begin
        if (!rst_n) ists <= '0;
        else        ists <= ((ists & ~ists_clr) | (int_evt & own)) & MASK;
    end

    // Wake status: clear by write-1, events set and win over clears
    always_ff @(posedge clk) begin
        if (!rst_n) wsts <= '0;
        else        wsts <= ((wsts & ~wsts_clr) | wake_evt) & MASK;
    end

    // Interrupt enable word: plain read/write of populated bits
    always_ff @(posedge clk) begin
        if (!rst_n)      ien <= '0;
        else if (wr_ien) ien <= wdata & MASK;
    end

    // Wake enable word: plain read/write of populated bits
    always_ff @(posedge clk) begin
        if (!rst_n)      wen <= '0;
        else if (wr_wen) wen <= wdata & MASK;
    end

    // Group-level pending summaries
    always_comb begin
        irq_hit  = |(ists & ien);
        wake_hit = |(wsts & wen & ~sci & MASK);
    end
endmodule

// File: rtl/gpi_or_reduce.sv
// Registered OR-reduction of a vector of hit flags; output is a level.
module gpi_or_reduce #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] hits,
    output logic             q
);
    // Register the OR of all hits
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= |hits;
    end
endmodule

// File: rtl/gpi_event_collector.sv
// Top of the grouped pad event collector: decodes the register bus, splits
// pad inputs into 24-pad groups, muxes read data and drives the two outputs.
// Assumes NUM_PADS <= 192 (eight groups) and one bus write per cycle.
module gpi_event_collector
    import gpi_pkg::*;
#(
    parameter int          NUM_PADS = 40,
    parameter int          ADDR_W   = 12,
    parameter logic [31:0] CFG_BASE = 32'h0000_0400
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic [NUM_PADS-1:0] int_evt,
    input  logic [NUM_PADS-1:0] wake_evt,
    input  logic [NUM_PADS-1:0] host_own,
    input  logic [NUM_PADS-1:0] route_sci,
    output logic                irq_out,
    output logic                wake_out
);
    localparam int NUM_GROUPS = (NUM_PADS + GROUP_PADS - 1) / GROUP_PADS;
    localparam int PAD_SPAN   = MAX_GROUPS * GROUP_PADS;

    bank_e               bank;
    logic [GIDX_W-1:0]   gidx;
    logic [PAD_SPAN-1:0] evt_pad, wevt_pad, own_pad, sci_pad;
    logic [PAD_SPAN-1:0] ists_flat;
    logic [GROUP_PADS-1:0] ists_w [MAX_GROUPS];
    logic [GROUP_PADS-1:0] ien_w  [MAX_GROUPS];
    logic [GROUP_PADS-1:0] wsts_w [MAX_GROUPS];
    logic [GROUP_PADS-1:0] wen_w  [MAX_GROUPS];
    logic [GROUP_PADS-1:0] own_w  [MAX_GROUPS];
    logic [MAX_GROUPS-1:0] irq_hits, wake_hits;
    logic                  pend_any, wake_any;

    gpi_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .bank (bank),
        .gidx (gidx)
    );

    // Zero-extend pad inputs to the full group span
    always_comb begin
        evt_pad  = '0;
        wevt_pad = '0;
        own_pad  = '0;
        sci_pad  = '0;
        evt_pad[NUM_PADS-1:0]  = int_evt;
        wevt_pad[NUM_PADS-1:0] = wake_evt;
        own_pad[NUM_PADS-1:0]  = host_own;
        sci_pad[NUM_PADS-1:0]  = route_sci;
    end

    for (genvar g = 0; g < MAX_GROUPS; g++) begin : g_grp
        if (g < NUM_GROUPS) begin : g_live
            gpi_group #(.GROUP_IDX(g), .NUM_PADS(NUM_PADS)) u_group (
                .clk      (clk),
                .rst_n    (rst_n),
                .int_evt  (evt_pad[g*GROUP_PADS +: GROUP_PADS]),
                .wake_evt (wevt_pad[g*GROUP_PADS +: GROUP_PADS]),
                .own      (own_pad[g*GROUP_PADS +: GROUP_PADS]),
                .sci      (sci_pad[g*GROUP_PADS +: GROUP_PADS]),
                .wr_ists  (bus_wr && bank == BK_ISTS && gidx == GIDX_W'(g)),
                .wr_ien   (bus_wr && bank == BK_IEN  && gidx == GIDX_W'(g)),
                .wr_wsts  (bus_wr && bank == BK_WSTS && gidx == GIDX_W'(g)),
                .wr_wen   (bus_wr && bank == BK_WEN  && gidx == GIDX_W'(g)),
                .wdata    (bus_wdata[GROUP_PADS-1:0]),
                .ists     (ists_w[g]),
                .ien      (ien_w[g]),
                .wsts     (wsts_w[g]),
                .wen      (wen_w[g]),
                .irq_hit  (irq_hits[g]),
                .wake_hit (wake_hits[g])
            );
            assign own_w[g] = own_pad[g*GROUP_PADS +: GROUP_PADS];
        end else begin : g_absent
            assign ists_w[g]    = '0;
            assign ien_w[g]     = '0;
            assign wsts_w[g]    = '0;
            assign wen_w[g]     = '0;
            assign own_w[g]     = '0;
            assign irq_hits[g]  = 1'b0;
            assign wake_hits[g] = 1'b0;
        end
        assign ists_flat[g*GROUP_PADS +: GROUP_PADS] = ists_w[g];
    end

    // Combine group summaries for the output registers
    always_comb begin
        pend_any = |irq_hits;
        wake_any = |wake_hits;
    end

    gpi_or_reduce #(.WIDTH(MAX_GROUPS)) u_irq_red (
        .clk   (clk),
        .rst_n (rst_n),
        .hits  (irq_hits),
        .q     (irq_out)
    );

    gpi_or_reduce #(.WIDTH(MAX_GROUPS)) u_wake_red (
        .clk   (clk),
        .rst_n (rst_n),
        .hits  (wake_hits),
        .q     (wake_out)
    );

    // Read data mux; upper byte of group words and the write data top byte unused
    always_comb begin
        bus_rdata = '0;
        unique case (bank)
            BK_CFG:  bus_rdata = CFG_BASE;
            BK_OWN:  bus_rdata = {{(WORD_W-GROUP_PADS){1'b0}}, own_w[gidx]};
            BK_ISTS: bus_rdata = {{(WORD_W-GROUP_PADS){1'b0}}, ists_w[gidx]};
            BK_IEN:  bus_rdata = {{(WORD_W-GROUP_PADS){1'b0}}, ien_w[gidx]};
            BK_WSTS: bus_rdata = {{(WORD_W-GROUP_PADS){1'b0}}, wsts_w[gidx]};
            BK_WEN:  bus_rdata = {{(WORD_W-GROUP_PADS){1'b0}}, wen_w[gidx]};
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpi_collector_checker.sv
// Property checker for the pad event collector, bound to its top module.
module gpi_collector_checker #(
    parameter int SPAN     = 192,
    parameter int NUM_PADS = 40
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_wr,
    input logic [SPAN-1:0] own_pad,
    input logic [SPAN-1:0] ists_flat,
    input logic            pend_any,
    input logic            wake_any,
    input logic            irq_out,
    input logic            wake_out
);
    // R3: with no bus write, no status bit can fall
    assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> (($past(ists_flat) & ~ists_flat) == '0));

    // R5: a bit that rises must belong to an owned pad
    assert_own_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ists_flat & ~$past(ists_flat) & ~$past(own_pad)) == '0));

    // R6: interrupt line follows enabled pending state by one cycle
    assert_irq_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_out == $past(pend_any)));

    // R7: no status bit beyond the pad count is ever set
    assert_unpop_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((ists_flat >> NUM_PADS) == '0));

    // R9: wake line follows qualified wake state by one cycle
    assert_wake_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (wake_out == $past(wake_any)));
endmodule

bind gpi_event_collector gpi_collector_checker #(
    .SPAN     (PAD_SPAN),
    .NUM_PADS (NUM_PADS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .own_pad   (own_pad),
    .ists_flat (ists_flat),
    .pend_any  (pend_any),
    .wake_any  (wake_any),
    .irq_out   (irq_out),
    .wake_out  (wake_out)
);

// File: tb/gpi_event_collector_bench.sv
module gpi_event_collector_bench;
    localparam int NP = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NP-1:0] int_evt = '0, wake_evt = '0, host_own = '1, route_sci = '0;
    logic        irq_out, wake_out;

    int total = 0;
    int bad   = 0;
    logic [31:0] rv;

    always #5 clk = ~clk;

    gpi_event_collector #(.NUM_PADS(NP), .ADDR_W(12), .CFG_BASE(32'h0000_0400)) u_gpi_event_collector (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .int_evt(int_evt),
        .wake_evt(wake_evt), .host_own(host_own), .route_sci(route_sci),
        .irq_out(irq_out), .wake_out(wake_out)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse_int(input logic [NP-1:0] m);
        @(negedge clk); int_evt = m;
        @(negedge clk); int_evt = '0;
    endtask

    task automatic pulse_wake(input logic [NP-1:0] m);
        @(negedge clk); wake_evt = m;
        @(negedge clk); wake_evt = '0;
    endtask

    // R11, R10: reset state and constant word
    task automatic t_reset();
        check("R11 irq", {31'b0, irq_out}, 0);
        check("R11 wake", {31'b0, wake_out}, 0);
        bus_read(12'h100, rv); check("R11 ists0", rv, 0);
        bus_read(12'h124, rv); check("R11 ien1", rv, 0);
        bus_read(12'h160, rv); check("R11 wen0", rv, 0);
        bus_read(12'h00C, rv); check("R10 cfg base", rv, 32'h400);
    endtask

    // R1, R2, R6, R3: mapping, stickiness, enable gating, clearing
    task automatic t_map_irq();
        pulse_int((NP'(1) << 5) | (NP'(1) << 30));
        bus_read(12'h100, rv); check("R1 R2 pad5", rv, 32'h20);
        bus_read(12'h104, rv); check("R1 R2 pad30", rv, 32'h40);
        @(negedge clk);
        bus_read(12'h104, rv); check("R2 sticky", rv, 32'h40);
        check("R6 masked irq", {31'b0, irq_out}, 0);
        bus_write(12'h124, 32'h40);
        @(negedge clk);
        check("R6 irq high", {31'b0, irq_out}, 1);
        bus_write(12'h104, 32'h40);
        bus_read(12'h104, rv); check("R3 cleared", rv, 0);
        @(negedge clk);
        check("R6 irq low", {31'b0, irq_out}, 0);
        bus_write(12'h100, 32'h0);
        bus_read(12'h100, rv); check("R3 zero write keeps", rv, 32'h20);
        bus_write(12'h100, 32'h20);
        bus_read(12'h100, rv); check("R3 clear pad5", rv, 0);
    endtask

    // R4: event and clear in the same cycle
    task automatic t_collision();
        pulse_int(NP'(1) << 3);
        @(negedge clk);
        int_evt = NP'(1) << 3;
        bus_addr = 12'h100; bus_wdata = 32'h8; bus_wr = 1'b1;
        @(negedge clk);
        int_evt = '0; bus_wr = 1'b0;
        bus_read(12'h100, rv); check("R4 event wins", rv, 32'h8);
        bus_write(12'h100, 32'h8);
        bus_read(12'h100, rv); check("R4 later clear", rv, 0);
    endtask

    // R5, R10: ownership gates status and reads back
    task automatic t_owner();
        host_own[7] = 1'b0;
        bus_read(12'h0A0, rv); check("R10 own0", rv, 32'h00FF_FF7F);
        bus_read(12'h0A4, rv); check("R10 own1", rv, 32'h0000_FFFF);
        pulse_int(NP'(1) << 7);
        bus_read(12'h100, rv); check("R5 unowned no set", rv, 0);
        host_own[7] = 1'b1;
        pulse_int(NP'(1) << 7);
        bus_read(12'h100, rv); check("R5 owned sets", rv, 32'h80);
        bus_write(12'h100, 32'h80);
    endtask

    // R7: unpopulated bits and groups
    task automatic t_unpop();
        bus_write(12'h124, 32'hFFFF_FFFF);
        bus_read(12'h124, rv); check("R7 partial group", rv, 32'h0000_FFFF);
        bus_write(12'h128, 32'hFFFF_FFFF);
        bus_read(12'h128, rv); check("R7 absent group", rv, 0);
        bus_write(12'h124, 32'h0);
        check("R7 irq quiet", {31'b0, irq_out}, 0);
    endtask

    // R8, R9: wake path with enable and steering
    task automatic t_wake();
        pulse_wake(NP'(1) << 26);
        bus_read(12'h144, rv); check("R8 wake sts", rv, 32'h4);
        check("R9 no enable", {31'b0, wake_out}, 0);
        bus_write(12'h164, 32'h4);
        @(negedge clk);
        check("R9 wake high", {31'b0, wake_out}, 1);
        route_sci[26] = 1'b1;
        @(negedge clk);
        check("R9 steered off", {31'b0, wake_out}, 0);
        route_sci[26] = 1'b0;
        @(negedge clk);
        check("R9 back on", {31'b0, wake_out}, 1);
        bus_write(12'h144, 32'h4);
        bus_read(12'h144, rv); check("R8 wake cleared", rv, 0);
        @(negedge clk);
        check("R9 low after clear", {31'b0, wake_out}, 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_map_irq();
                t_collision();
                t_owner();
                t_unpop();
                t_wake();
            end
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog got=hang exp=done");
            end
        join_any
        disable fork;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule